// File: doc/BRIEF.md
# Address-Space Port Router and Decoder

This block sits on a processor's external bus and decides, for every transfer, which of two external ports (A or B) carries it. A transfer is named by a 2-bit address-space code (program, X data or Y data) and a 32-bit address, qualified by an active-low transfer strobe and a read/write line. Each address space is cut into eight equal sections by the top three address bits, and a 24-bit steering register holds one bit per section: 0 sends the transfer to port A, 1 to port B. The strobe is copied onto the chosen port's strobe output only.

Alongside the steering, four fixed-address decoders raise active-low selects for memory-mapped devices. Two Y-space addresses select a remote processor's mailbox (one for a transmit-data write, one for a control/status read), with address bits 5 down to 2 handed to the mailbox as its function code. A fixed Y-space address selects a write-only output latch, and a fixed X-space address selects a read-only input latch. A select fires only while the strobe is low and only when the transfer is steered to the port the device hangs on (mailbox and output latch on port B, input latch on port A). The transfer acknowledge is held low, so every transfer completes with no wait states.

The steering register is loaded through a one-cycle load port. A small two-state tracker (ST_IDLE, ST_XFER) keeps the steering frozen during a transfer: it moves ST_IDLE to ST_XFER on an edge where the strobe is low, and ST_XFER to ST_IDLE on an edge where the strobe is high. A load is taken only in ST_IDLE with the strobe high.

Top module: `xbus_port_router`

## Requirements
- R1: After reset the steering register is all zeros, so every valid transfer goes to port A.
- R2: For space codes 00 (program), 01 (X) and 10 (Y), the steering bit index is space*8 + addr[31:29]; bit value 0 gives port A, 1 gives port B. In the same cycle the strobe appears on only that port's strobe output, the other stays high, and the port-B indicator equals the bit.
- R3: Space code 11 means no transfer: both port strobes stay high, the port-B indicator is 0 and no select fires.
- R4: The transfer acknowledge output is always 0.
- R5: A load pulse in ST_IDLE with the strobe high writes the load data into the steering register; steering follows it from the next cycle.
- R6: A load pulse while the strobe is low, or in the cycle after a transfer while still in ST_XFER, is dropped and the steering register keeps its value.
- R7: The mailbox select (low) fires iff the strobe is low, the space is Y (10), the address equals 0xFFFFFF94 (transmit write) or 0xFFFFFF88 (status read), and the transfer is steered to port B.
- R8: The mailbox function-code output equals addr[5:2] and the mailbox read/write output equals the read/write input (1 = read).
- R9: The output-latch select (low) fires iff the strobe is low, space Y, address 0xFFFFFFFC, read/write 0 (write), and the transfer is steered to port B.
- R10: The input-latch select (low) fires iff the strobe is low, space X (01), address 0xFFFFFFFC, read/write 1 (read), and the transfer is steered to port A.
- R11: With the strobe high, no port strobe and no select is asserted, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| steer_load_i | input | 1 | Load pulse for the steering register |
| steer_data_i | input | 24 | Steering value; bit space*8+section |
| space_i | input | 2 | Address-space code: 00 program, 01 X, 10 Y, 11 none |
| addr_i | input | 32 | Transfer address |
| rd_i | input | 1 | 1 = read, 0 = write |
| strobe_n_i | input | 1 | Active-low transfer strobe |
| strobe_a_n_o | output | 1 | Strobe to port A (active low) |
| strobe_b_n_o | output | 1 | Strobe to port B (active low) |
| route_b_o | output | 1 | 1 when the transfer is steered to port B |
| ack_n_o | output | 1 | Transfer acknowledge, held at 0 |
| mbox_sel_n_o | output | 1 | Remote mailbox select (active low) |
| mbox_fn_o | output | 4 | Mailbox function code, addr[5:2] |
| mbox_rd_o | output | 1 | Mailbox read/write line |
| olatch_sel_n_o | output | 1 | Output latch select (active low) |
| ilatch_sel_n_o | output | 1 | Input latch select (active low) |

## Verification
Every routing and select output is combinational from the bus inputs and the steering register, so it is due in the same cycle the stimulus is applied; the bench drives on the falling edge and samples 5 ns later, before the next rising edge. A steering load is due one rising edge after the load pulse, so the bench applies its first probing transfer on the falling edge right after that edge. For the dropped-load case the bench holds the strobe low across the load edge and then sweeps all 24 sections to see the old value still steering.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
    typedef enum logic [1:0] {
        SP_PROG = 2'b00,
        SP_X    = 2'b01,
        SP_Y    = 2'b10,
        SP_NONE = 2'b11
    } space_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } acc_state_e;

    localparam int NUM_SPACES = 3;
endpackage

// File: rtl/rtr_steer_reg.sv
module rtr_steer_reg
    import rtr_pkg::*;
#(
    parameter int STEER_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe_n_i,
    input  logic               load_i,
    input  logic [STEER_W-1:0] data_i,
    output logic [STEER_W-1:0] steer_o
);
    acc_state_e state_q, state_d;
    logic       take_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!strobe_n_i) state_d = ST_XFER;
            ST_XFER: if (strobe_n_i)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_load = load_i && strobe_n_i && (state_q == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         steer_o <= '0;
        else if (take_load) steer_o <= data_i;
    end

    // R6: no change while a transfer is open
    p_hold_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |=> $stable(steer_o));
    // R6: no change on an edge with the strobe low
    p_hold_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n_i) |=> $stable(steer_o));
    // R5: accepted load lands next cycle
    p_load_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && strobe_n_i && state_q == ST_IDLE) |=> (steer_o == $past(data_i)));
endmodule

// File: rtl/rtr_port_steer.sv
module rtr_port_steer
    import rtr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SECT_BITS = 3,
    parameter int STEER_W   = 24
) (
    input  logic [1:0]         space_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [STEER_W-1:0] steer_i,
    output logic               valid_o,
    output logic               port_b_o
);
    localparam int IDX_W = $clog2(STEER_W);

    logic [SECT_BITS-1:0] section;
    logic [IDX_W-1:0]     idx;

    always_comb begin
        section  = addr_i[ADDR_W-1 -: SECT_BITS];
        valid_o  = (space_i != SP_NONE);
        idx      = IDX_W'({space_i, section});
        port_b_o = valid_o ? steer_i[idx] : 1'b0;
    end
endmodule

// File: rtl/rtr_addr_match.sv
module rtr_addr_match #(
    parameter int          ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] MATCH_ADDR  = '1,
    parameter logic [1:0]  MATCH_SPACE = 2'b10
) (
    input  logic [1:0]        space_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    always_comb hit_o = (space_i == MATCH_SPACE) && (addr_i == MATCH_ADDR);
endmodule

// File: rtl/xbus_port_router.sv
module xbus_port_router
    import rtr_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter int                SECT_BITS     = 3,
    parameter logic [ADDR_W-1:0] MBOX_TX_ADDR  = 32'hFFFF_FF94,
    parameter logic [ADDR_W-1:0] MBOX_ST_ADDR  = 32'hFFFF_FF88,
    parameter logic [ADDR_W-1:0] OLATCH_ADDR   = 32'hFFFF_FFFC,
    parameter logic [ADDR_W-1:0] ILATCH_ADDR   = 32'hFFFF_FFFC,
    localparam int               STEER_W       = NUM_SPACES << SECT_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               steer_load_i,
    input  logic [STEER_W-1:0] steer_data_i,
    input  logic [1:0]         space_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               rd_i,
    input  logic               strobe_n_i,
    output logic               strobe_a_n_o,
    output logic               strobe_b_n_o,
    output logic               route_b_o,
    output logic               ack_n_o,
    output logic               mbox_sel_n_o,
    output logic [3:0]         mbox_fn_o,
    output logic               mbox_rd_o,
    output logic               olatch_sel_n_o,
    output logic               ilatch_sel_n_o
);
    localparam int NUM_DEC = 4;
    localparam logic [ADDR_W-1:0] DEC_ADDR [NUM_DEC] =
        '{MBOX_TX_ADDR, MBOX_ST_ADDR, OLATCH_ADDR, ILATCH_ADDR};
    localparam logic [1:0] DEC_SPACE [NUM_DEC] = '{2'b10, 2'b10, 2'b10, 2'b01};

    logic [STEER_W-1:0] steer_q;
    logic               valid, port_b, live;
    logic [NUM_DEC-1:0] hit;

    rtr_steer_reg #(.STEER_W(STEER_W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n_i (strobe_n_i),
        .load_i     (steer_load_i),
        .data_i     (steer_data_i),
        .steer_o    (steer_q)
    );

    rtr_port_steer #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .STEER_W(STEER_W)) u_steer (
        .space_i  (space_i),
        .addr_i   (addr_i),
        .steer_i  (steer_q),
        .valid_o  (valid),
        .port_b_o (port_b)
    );

    for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
        rtr_addr_match #(
            .ADDR_W      (ADDR_W),
            .MATCH_ADDR  (DEC_ADDR[g]),
            .MATCH_SPACE (DEC_SPACE[g])
        ) u_match (
            .space_i (space_i),
            .addr_i  (addr_i),
            .hit_o   (hit[g])
        );
    end

    always_comb begin
        live           = valid && !strobe_n_i;
        strobe_a_n_o   = !(live && !port_b);
        strobe_b_n_o   = !(live && port_b);
        route_b_o      = port_b;
        ack_n_o        = 1'b0;
        mbox_sel_n_o   = !(live && port_b && (hit[0] || hit[1]));
        olatch_sel_n_o = !(live && port_b && hit[2] && !rd_i);
        ilatch_sel_n_o = !(live && !port_b && hit[3] && rd_i);
        mbox_fn_o      = addr_i[5:2];
        mbox_rd_o      = rd_i;
    end

    // R2: at most one port strobe at a time
    p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!strobe_a_n_o, !strobe_b_n_o}));
    // R3: no-access code drives nothing
    p_no_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (space_i == SP_NONE) |-> (strobe_a_n_o && strobe_b_n_o && mbox_sel_n_o
                                   && olatch_sel_n_o && ilatch_sel_n_o));
    // R11: selects only under the strobe
    p_sel_needs_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mbox_sel_n_o || !olatch_sel_n_o || !ilatch_sel_n_o) |-> !strobe_n_i);
    // R7: mailbox only on a port-B Y transfer
    p_mbox_y_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mbox_sel_n_o |-> (space_i == SP_Y && !strobe_b_n_o));
    // R9: output latch only written
    p_olatch_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !olatch_sel_n_o |-> (!rd_i && !strobe_b_n_o));
    // R10: input latch only read, on port A
    p_ilatch_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ilatch_sel_n_o |-> (rd_i && !strobe_a_n_o));
endmodule

// File: tb/sim_xbus_port_router.sv
module sim_xbus_port_router;
    localparam logic [31:0] A_TX = 32'hFFFF_FF94;
    localparam logic [31:0] A_ST = 32'hFFFF_FF88;
    localparam logic [31:0] A_LT = 32'hFFFF_FFFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        steer_load_i = 1'b0;
    logic [23:0] steer_data_i = '0;
    logic [1:0]  space_i = 2'b11;
    logic [31:0] addr_i = '0;
    logic        rd_i = 1'b1;
    logic        strobe_n_i = 1'b1;
    logic        strobe_a_n_o, strobe_b_n_o, route_b_o, ack_n_o;
    logic        mbox_sel_n_o, mbox_rd_o, olatch_sel_n_o, ilatch_sel_n_o;
    logic [3:0]  mbox_fn_o;

    int checks = 0;
    int errors = 0;
    logic [23:0] model = '0;

    always #10 clk = ~clk;

    xbus_port_router u0 (
        .clk(clk), .rst_n(rst_n), .steer_load_i(steer_load_i), .steer_data_i(steer_data_i),
        .space_i(space_i), .addr_i(addr_i), .rd_i(rd_i), .strobe_n_i(strobe_n_i),
        .strobe_a_n_o(strobe_a_n_o), .strobe_b_n_o(strobe_b_n_o), .route_b_o(route_b_o),
        .ack_n_o(ack_n_o), .mbox_sel_n_o(mbox_sel_n_o), .mbox_fn_o(mbox_fn_o),
        .mbox_rd_o(mbox_rd_o), .olatch_sel_n_o(olatch_sel_n_o), .ilatch_sel_n_o(ilatch_sel_n_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one transfer, check in the same cycle, then release and idle a cycle.
    task automatic xfer(input string tag, input logic [1:0] sp, input logic [31:0] a, input logic rd);
        logic valid, pb, mb, ol, il;
        @(negedge clk);
        space_i = sp; addr_i = a; rd_i = rd; strobe_n_i = 1'b0;
        #5;
        valid = (sp != 2'b11);
        pb    = valid && model[{sp, a[31:29]}];
        mb    = valid && sp == 2'b10 && pb && (a == A_TX || a == A_ST);
        ol    = sp == 2'b10 && pb && a == A_LT && !rd;
        il    = sp == 2'b01 && !pb && a == A_LT && rd;
        // R2 / R3 routing, tag names the scenario
        chk({tag, " R2 R3 route"}, {29'd0, route_b_o, strobe_a_n_o, strobe_b_n_o},
            {29'd0, pb, !(valid && !pb), !(valid && pb)});
        // R7 R9 R10 selects
        chk({tag, " R7 R9 R10 sel"}, {29'd0, mbox_sel_n_o, olatch_sel_n_o, ilatch_sel_n_o},
            {29'd0, !mb, !ol, !il});
        // R8 function code and direction
        chk({tag, " R8 fn"}, {27'd0, mbox_fn_o, mbox_rd_o}, {27'd0, a[5:2], rd});
        chk({tag, " R4 ack"}, {31'd0, ack_n_o}, 32'd0);
        @(negedge clk);
        strobe_n_i = 1'b1;
        // R11: strobe high, same address: nothing asserted
        #5;
        chk({tag, " R11 idle"}, {27'd0, strobe_a_n_o, strobe_b_n_o, mbox_sel_n_o,
            olatch_sel_n_o, ilatch_sel_n_o}, {27'd0, 5'b11111});
        @(negedge clk);
    endtask

    task automatic load(input logic [23:0] v);
        @(negedge clk);
        steer_load_i = 1'b1; steer_data_i = v;
        @(negedge clk);
        steer_load_i = 1'b0;
        model = v;
    endtask

    task automatic sweep(input string tag);
        for (int sp = 0; sp < 4; sp++)
            for (int sec = 0; sec < 8; sec++)
                xfer(tag, 2'(sp), {3'(sec), 29'(sec * 36 + 4)}, 1'(sec & 1));
        for (int sp = 0; sp < 4; sp++)
            for (int r = 0; r < 2; r++) begin
                xfer(tag, 2'(sp), A_TX, 1'(r));
                xfer(tag, 2'(sp), A_ST, 1'(r));
                xfer(tag, 2'(sp), A_LT, 1'(r));
                xfer(tag, 2'(sp), 32'hFFFF_FFF8, 1'(r));
            end
    endtask

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset value steers everything to port A
        sweep("R1 reset");
        // R5: loads take effect on the next cycle
        load(24'hFFFFFF); sweep("R5 ones");
        load(24'hAAAAAA); sweep("R5 alt");
        load(24'h80007F); sweep("R5 mixed");
        load(24'h00FF00); sweep("R5 xonly");
        // R6: load while the strobe is low is dropped
        @(negedge clk);
        space_i = 2'b10; addr_i = 32'h0; strobe_n_i = 1'b0;
        steer_load_i = 1'b1; steer_data_i = 24'h5A5A5A;
        @(negedge clk);
        steer_load_i = 1'b0; strobe_n_i = 1'b1;
        // R6: load in the release cycle (still ST_XFER) is dropped
        steer_load_i = 1'b1; steer_data_i = 24'h123456;
        @(negedge clk);
        steer_load_i = 1'b0;
        sweep("R6 dropped");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule